// File: doc/BRIEF.md
# Status Byte and Write-Permission Unit

This unit keeps the status byte of a serial byte-addressed nonvolatile memory and rules on every write request that reaches it. It holds a volatile write-enable flag, a busy flag driven by an internal write-cycle timer, and three protection bits that behave as nonvolatile: a pin-lock enable and a two-bit fence code. The fence code picks the protected part of the array: nothing, the top quarter, the top half, or the whole array.

The serial front end drives the unit with strobes. These strobes set or clear the enable flag, load a status byte while chip select is still low, and commit the loaded byte or an array write when chip select rises. The front end also issues array-write permission queries with an address. The unit answers each query one cycle later with either a grant or a deny. It always presents the byte that a status read returns. A hardware write-protect pin, active low, joins the permission table through the pin-lock enable bit.

Top module: `srwp_unit`

## Requirements
- R1: After reset the status byte reads 8'h00: not busy, enable flag clear, pin-lock enable 0, fence code 00.
- R2: When idle, the status byte is {lock, 3'b000, fence[1], fence[0], wen, 1'b0}. Bit 7 is the pin-lock enable, bits 6 to 4 read as zero, bits 3 and 2 are the fence code, bit 1 is the enable flag and bit 0 is busy.
- R3: A committed status or array write makes the status byte read 8'hFF for exactly WR_CYCLES cycles, beginning the cycle after the commit strobe.
- R4: The enable flag is cleared by the clear strobe whatever the write-protect pin does, and it is cleared when a write cycle ends.
- R5: For a 14-bit address, fence code 01 protects 0x3000 to 0x3FFF, 10 protects 0x2000 to 0x3FFF, 11 protects the whole array and 00 protects nothing. A protected address is always denied.
- R6: With the enable flag clear, array queries are denied and a status load followed by a commit leaves the status byte unchanged.
- R7: With the pin low and the pin-lock enable at 1, status writes are refused, including one that would clear the pin-lock enable. With the pin high, the same status write is accepted.
- R8: A pin fall between a status load and its commit, with the pin-lock enable at 1, aborts that status write. A pin fall after the commit has no effect on it.
- R9: A status write changes only bits 7, 3 and 2, and only at the commit strobe. A load alone changes nothing.
- R10: While busy, array queries are denied and enable, load and commit strobes are ignored.
- R11: Each array query gives exactly one of grant or deny, in the cycle after the query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Write-protect pin, active low |
| wen_set | input | 1 | Strobe: set the enable flag |
| wen_clr | input | 1 | Strobe: clear the enable flag |
| sr_load | input | 1 | Strobe: status data byte received, chip select still low |
| sr_data | input | 8 | Status byte to load |
| sr_commit | input | 1 | Strobe: chip select rose after a status write |
| arr_req | input | 1 | Array-write permission query |
| arr_addr | input | ADDR_W | Byte address of the query |
| arr_commit | input | 1 | Strobe: chip select rose after array data |
| arr_grant | output | 1 | Query granted (one cycle after arr_req) |
| arr_deny | output | 1 | Query denied (one cycle after arr_req) |
| status_o | output | 8 | Byte returned by a status read |

## Verification
The assertions check on every cycle the behaviour that can be stated in terms of the ports. They check that grant and deny are exclusive and follow each query, that a busy status is all ones, that idle bits 6 to 4 stay zero, and that the enable flag is low once busy ends. They also check that a grant never follows a clear enable flag or a full fence, that the protection bits move only on a commit, and that the pin lock holds the lock bit. The bench scenarios are needed for the full fence boundaries under each code and the exact busy length. They also cover aborting a loaded write by a pin fall, contrasted with the same fall after commit, and strobes that are dropped during a write cycle.

// File: rtl/srwp_pkg.sv
package srwp_pkg;
  typedef struct packed {
    logic       lock;
    logic [1:0] fence;
  } prot_bits_t;

  function automatic logic [7:0] pack_status(input prot_bits_t p, input logic wen,
                                             input logic busy);
    pack_status = busy ? 8'hFF : {p.lock, 3'b000, p.fence, wen, 1'b0};
  endfunction
endpackage

// File: rtl/srwp_fence.sv
module srwp_fence #(
  parameter int ADDR_W = 14
) (
  input  logic [1:0]        fence,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int MSB = ADDR_W - 1;
  logic [1:0] top2;
  assign top2 = addr[MSB -: 2];

  always_comb begin
    unique case (fence)
      2'b00:   hit = 1'b0;
      2'b01:   hit = (top2 == 2'b11);
      2'b10:   hit = top2[1];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/srwp_timer.sv
module srwp_timer #(
  parameter int WR_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD = CW'(WR_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_d;

  assign done = busy & (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy;
    if (!busy && start) begin
      cnt_d  = LOAD;
      busy_d = 1'b1;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      busy  <= busy_d;
    end
  end
endmodule

// File: rtl/srwp_unit.sv
module srwp_unit
  import srwp_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int WR_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              wen_set,
  input  logic              wen_clr,
  input  logic              sr_load,
  input  logic [7:0]        sr_data,
  input  logic              sr_commit,
  input  logic              arr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              arr_commit,
  output logic              arr_grant,
  output logic              arr_deny,
  output logic [7:0]        status_o
);
  prot_bits_t prot_q, prot_d, pend_bits_q, pend_bits_d;
  logic wen_q, wen_d, pend_q, pend_d;
  logic grant_d, deny_d;
  logic busy, done, hw_lock, fence_hit, sr_go, arr_go, start;
  logic unused_bits;

  assign unused_bits = ^{sr_data[6:4], sr_data[1:0]};

  srwp_fence #(.ADDR_W(ADDR_W)) u_fence (
    .fence (prot_q.fence),
    .addr  (arr_addr),
    .hit   (fence_hit)
  );

  srwp_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done)
  );

  assign hw_lock = ~wp_n & prot_q.lock;
  assign sr_go   = sr_commit & pend_q & ~hw_lock & ~busy;
  assign arr_go  = arr_commit & wen_q & ~busy & ~sr_go;
  assign start   = sr_go | arr_go;

  always_comb begin
    wen_d = wen_q;
    if (done)                   wen_d = 1'b0;
    else if (!busy && wen_clr)  wen_d = 1'b0;
    else if (!busy && wen_set)  wen_d = 1'b1;
  end

  always_comb begin
    pend_d      = pend_q;
    pend_bits_d = pend_bits_q;
    if (sr_load && !busy) begin
      pend_d      = wen_q & ~hw_lock;
      pend_bits_d = '{lock: sr_data[7], fence: sr_data[3:2]};
    end else if (hw_lock || sr_commit || busy) begin
      pend_d = 1'b0;
    end
  end

  always_comb begin
    prot_d = prot_q;
    if (sr_go) prot_d = pend_bits_q;
  end

  assign grant_d = arr_req & ~busy & wen_q & ~fence_hit;
  assign deny_d  = arr_req & ~grant_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q       <= 1'b0;
      pend_q      <= 1'b0;
      pend_bits_q <= '0;
      prot_q      <= '0;
      arr_grant   <= 1'b0;
      arr_deny    <= 1'b0;
    end else begin
      wen_q       <= wen_d;
      pend_q      <= pend_d;
      pend_bits_q <= pend_bits_d;
      prot_q      <= prot_d;
      arr_grant   <= grant_d;
      arr_deny    <= deny_d;
    end
  end

  assign status_o = pack_status(prot_q, wen_q, busy);
endmodule

// File: rtl/srwp_unit_chk.sv
module srwp_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n,
  input logic       arr_req,
  input logic       arr_grant,
  input logic       arr_deny,
  input logic       sr_commit,
  input logic [7:0] status_o,
  input logic       lock_q,
  input logic [1:0] fence_q
);
  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_grant, arr_deny}));
  assert_answer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req |=> (arr_grant ^ arr_deny));
  assert_busy_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] |-> (status_o == 8'hFF));
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[0] |-> (status_o[6:4] == 3'b000));
  assert_wen_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_o[0]) |-> !status_o[1]);
  assert_grant_wen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_grant |-> $past(status_o[1] && !status_o[0]));
  assert_full_fence_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_grant |-> $past(fence_q != 2'b11));
  assert_bits_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sr_commit) |-> $stable({lock_q, fence_q}));
  assert_pin_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && lock_q) |=> lock_q);
endmodule

bind srwp_unit srwp_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wp_n      (wp_n),
  .arr_req   (arr_req),
  .arr_grant (arr_grant),
  .arr_deny  (arr_deny),
  .sr_commit (sr_commit),
  .status_o  (status_o),
  .lock_q    (prot_q.lock),
  .fence_q   (prot_q.fence)
);

// File: tb/tb_srwp_unit.sv
module tb_srwp_unit;
  localparam int ADDR_W = 14;
  localparam int WR_CYCLES = 16;

  logic clk, rst_n, wp_n, wen_set, wen_clr, sr_load, sr_commit, arr_req, arr_commit;
  logic [7:0] sr_data;
  logic [ADDR_W-1:0] arr_addr;
  logic arr_grant, arr_deny;
  logic [7:0] status_o;
  int checks = 0, bad = 0, cyc = 0;

  srwp_unit #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {fence[1:0], wen, addr[13:0], expect_grant}
  localparam logic [17:0] VEC [8] = '{
    {2'b00, 1'b1, 14'h3FFF, 1'b1},
    {2'b01, 1'b1, 14'h3000, 1'b0},
    {2'b01, 1'b1, 14'h2FFF, 1'b1},
    {2'b10, 1'b1, 14'h2000, 1'b0},
    {2'b10, 1'b1, 14'h1FFF, 1'b1},
    {2'b11, 1'b1, 14'h0000, 1'b0},
    {2'b00, 1'b0, 14'h0123, 1'b0},
    {2'b01, 1'b0, 14'h0000, 1'b0}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic pulse_set();    wen_set = 1; tick(); wen_set = 0; endtask
  task automatic pulse_clr();    wen_clr = 1; tick(); wen_clr = 0; endtask
  task automatic pulse_commit(); sr_commit = 1; tick(); sr_commit = 0; endtask
  task automatic pulse_load(input logic [7:0] d);
    sr_data = d; sr_load = 1; tick(); sr_load = 0;
  endtask
  task automatic query(input logic [ADDR_W-1:0] a);
    arr_addr = a; arr_req = 1; tick(); arr_req = 0;
  endtask
  task automatic write_status(input logic [7:0] d);
    pulse_set(); pulse_load(d); pulse_commit();
    repeat (WR_CYCLES + 1) tick();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wp_n = 1; wen_set = 0; wen_clr = 0; sr_load = 0; sr_commit = 0;
    arr_req = 0; arr_commit = 0; sr_data = 0; arr_addr = 0;
    repeat (3) tick();
    rst_n = 1; tick();
    check("R1 reset status", status_o, 8'h00);

    // Vector table: fence ranges and enable gating (R5, R6, R11)
    for (int i = 0; i < 8; i++) begin
      write_status({4'b0000, VEC[i][17:16], 2'b00});
      if (VEC[i][15]) pulse_set(); else pulse_clr();
      query(VEC[i][14:1]);
      check($sformatf("R5 R6 R11 vec%0d grant/deny", i), {6'b0, arr_grant, arr_deny},
            {6'b0, VEC[i][0], ~VEC[i][0]});
    end

    // R6: status write with enable clear does nothing
    write_status(8'h00);
    pulse_clr(); pulse_load(8'h8C); pulse_commit();
    check("R6 status write refused", status_o, 8'h00);

    // R2 R9: load alone changes nothing; commit writes only bits 7,3,2
    pulse_set(); pulse_load(8'hFF);
    check("R9 load only", status_o, 8'h02);
    pulse_commit();
    // R3: busy for exactly WR_CYCLES cycles
    check("R3 busy start", status_o, 8'hFF);
    pulse_set(); // R10: ignored while busy
    query(14'h0000);
    check("R10 query while busy", {6'b0, arr_grant, arr_deny}, 8'h01);
    repeat (WR_CYCLES - 3) tick();
    check("R3 busy last cycle", status_o, 8'hFF);
    tick();
    check("R2 R4 R9 after write", status_o, 8'h8C);

    // R7: pin low with lock set refuses write, even clearing lock
    wp_n = 0;
    pulse_set(); pulse_load(8'h00); pulse_commit();
    check("R7 locked refuse", status_o, 8'h8E);
    pulse_clr();
    check("R4 clear with pin low", status_o, 8'h8C);
    wp_n = 1;
    write_status(8'h80);
    check("R7 pin high accepted", status_o, 8'h80);

    // R8: pin fall between load and commit aborts
    pulse_set(); pulse_load(8'h88);
    wp_n = 0; tick(); wp_n = 1;
    pulse_commit();
    check("R8 aborted", status_o, 8'h82);
    // R8: pin fall after commit has no effect
    pulse_load(8'h0C); pulse_commit();
    wp_n = 0;
    repeat (WR_CYCLES + 1) tick();
    wp_n = 1;
    check("R8 after commit", status_o, 8'h0C);

    // R10: load/commit during array write cycle ignored; R4 cleared at end
    pulse_set();
    arr_commit = 1; tick(); arr_commit = 0;
    check("R3 array busy", status_o, 8'hFF);
    pulse_load(8'h00); pulse_commit();
    repeat (WR_CYCLES) tick();
    check("R10 R4 strobes ignored", status_o, 8'h0C);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule